// File: doc/BRIEF.md
# Shared-Bus Ownership Arbiter with Refresh Preemption

This block decides who drives a shared memory bus: the processor core, an external bus master using a hold/acknowledge handshake, a cascaded DMA requester using a request/acknowledge handshake with an active-low acknowledge, or the internal DRAM refresh engine. The external request pins never reach the core directly. The arbiter raises its own hold request toward the core, waits for the core's acknowledge, and only then hands the bus to a requester.

Refresh has a special right. If it asks for the bus while an external master or the DMA cascade holds a grant, the arbiter withdraws that grant even though the request is still high. The withdrawn requester is then locked out until it drops its request for at least one clock and raises it again. Every handover includes one cycle in which nobody holds a grant.

The controller has five states:
- `ST_IDLE`: the core owns the bus and no hold request is raised.
- `ST_ARB`: the hold request is raised and no grant is given.
- `ST_HOLD`, `ST_DMA`, `ST_RFSH`: one owner each.

Its transitions are:
- IDLE→ARB when any eligible request is present.
- ARB→IDLE when no eligible request remains.
- ARB→RFSH/DMA/HOLD once the core acknowledge is seen, choosing the highest-priority eligible request.
- HOLD/DMA→ARB when the owner drops its request, or when refresh asks for the bus. The second case is a withdrawal.
- RFSH→ARB when the refresh request falls.

Top module: `bus_arbiter`

## Requirements
- R1: While reset is asserted and after its release with no request, hold grant = 0, DMA acknowledge (active low) = 1, refresh grant = 0 and core hold request = 0.
- R2: External hold and DMA requests pass through a SYNC_STAGES-flop synchronizer. With SYNC_STAGES = 2, the core hold request rises at the third rising edge after a request from idle, and not before.
- R3: A grant to any non-core owner rises only if the core hold acknowledge was high in the preceding cycle.
- R4: When several eligible requests are pending at arbitration, refresh wins over DMA, and DMA wins over external hold.
- R5: An external hold or DMA grant persists while its request stays high and refresh does not ask. A lower- or higher-priority external request does not preempt it.
- R6: A refresh request while hold or DMA is granted removes that grant at the next edge, with the request still high. The refresh grant follows one edge later.
- R7: A withdrawn requester is ignored until its synchronized request has been low for at least one clock. After that, a new high request is granted normally.
- R8: The refresh grant stays high as long as the refresh request is high, and falls at the edge after the request drops.
- R9: At most one grant is active at a time. Every grant rises from a cycle in which no grant was active.
- R10: The core hold request is high whenever any grant is active. It falls once no eligible request remains.
- R11: When a granted external owner drops its request, its grant is removed, and another pending eligible request is served after one dead cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_hold_i | input | 1 | External master bus request (asynchronous) |
| ext_hold_gnt_o | output | 1 | Grant to external master |
| cas_req_i | input | 1 | DMA cascade request (asynchronous) |
| cas_ack_n_o | output | 1 | DMA cascade acknowledge, active low |
| rfsh_req_i | input | 1 | Refresh engine request (synchronous) |
| rfsh_gnt_o | output | 1 | Refresh grant |
| core_hold_req_o | output | 1 | Hold request to the core |
| core_hold_ack_i | input | 1 | Hold acknowledge from the core (synchronous) |

## Verification
The bench builds the arbiter with SYNC_STAGES = 2. At that depth the latency from a raw pin change to the core hold request is a fixed three edges, so the bench can check the synchronizer depth and the acknowledge wait cycle by cycle instead of only after settling. The bench models the core acknowledge as a one-cycle registered copy of the hold request. This brings the back-to-back handover (owner to dead cycle to refresh) and the one-clock release pulse that clears a lockout into exact, countable windows.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB,
        ST_HOLD,
        ST_DMA,
        ST_RFSH
    } arb_state_e;
endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/arb_release_flag.sv
module arb_release_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic req_s_i,
    input  logic withdraw_i,
    output logic eligible_o
);
    logic locked_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     locked_q <= 1'b0;
        else if (withdraw_i && req_s_i) locked_q <= 1'b1;
        else if (!req_s_i)              locked_q <= 1'b0;
    end

    assign eligible_o = req_s_i && !locked_q;
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
    import arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_ok_i,
    input  logic dma_ok_i,
    input  logic rfsh_req_i,
    input  logic core_ack_i,
    output logic wd_hold_o,
    output logic wd_dma_o,
    output logic hold_gnt_o,
    output logic dma_gnt_o,
    output logic rfsh_gnt_o,
    output logic core_req_o
);
    arb_state_e state_q, state_d;
    logic       any_req;

    assign any_req = rfsh_req_i || dma_ok_i || hold_ok_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        wd_hold_o = 1'b0;
        wd_dma_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: if (any_req) state_d = ST_ARB;
            ST_ARB: begin
                if (!any_req)        state_d = ST_IDLE;
                else if (core_ack_i) begin
                    if (rfsh_req_i)    state_d = ST_RFSH;
                    else if (dma_ok_i) state_d = ST_DMA;
                    else               state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (!hold_ok_i) state_d = ST_ARB;
                else if (rfsh_req_i) begin
                    state_d   = ST_ARB;
                    wd_hold_o = 1'b1;
                end
            end
            ST_DMA: begin
                if (!dma_ok_i) state_d = ST_ARB;
                else if (rfsh_req_i) begin
                    state_d  = ST_ARB;
                    wd_dma_o = 1'b1;
                end
            end
            ST_RFSH: if (!rfsh_req_i) state_d = ST_ARB;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        hold_gnt_o = (state_q == ST_HOLD);
        dma_gnt_o  = (state_q == ST_DMA);
        rfsh_gnt_o = (state_q == ST_RFSH);
        core_req_o = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_hold_i,
    output logic ext_hold_gnt_o,
    input  logic cas_req_i,
    output logic cas_ack_n_o,
    input  logic rfsh_req_i,
    output logic rfsh_gnt_o,
    output logic core_hold_req_o,
    input  logic core_hold_ack_i
);
    localparam int NUM_EXT = 2;
    localparam int IDX_HOLD = 0;
    localparam int IDX_DMA  = 1;

    logic [NUM_EXT-1:0] raw_req, sync_req, eligible, withdraw;
    logic               dma_gnt;

    assign raw_req[IDX_HOLD] = ext_hold_i;
    assign raw_req[IDX_DMA]  = cas_req_i;

    arb_sync #(.WIDTH(NUM_EXT), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_req),
        .q_o   (sync_req)
    );

    for (genvar i = 0; i < NUM_EXT; i++) begin : g_lock
        arb_release_flag u_flag (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_s_i    (sync_req[i]),
            .withdraw_i (withdraw[i]),
            .eligible_o (eligible[i])
        );
    end

    arb_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_ok_i  (eligible[IDX_HOLD]),
        .dma_ok_i   (eligible[IDX_DMA]),
        .rfsh_req_i (rfsh_req_i),
        .core_ack_i (core_hold_ack_i),
        .wd_hold_o  (withdraw[IDX_HOLD]),
        .wd_dma_o   (withdraw[IDX_DMA]),
        .hold_gnt_o (ext_hold_gnt_o),
        .dma_gnt_o  (dma_gnt),
        .rfsh_gnt_o (rfsh_gnt_o),
        .core_req_o (core_hold_req_o)
    );

    assign cas_ack_n_o = !dma_gnt;
endmodule

// File: rtl/arb_checker.sv
module arb_checker (
    input logic clk,
    input logic rst_n,
    input logic ext_hold_gnt_o,
    input logic cas_ack_n_o,
    input logic rfsh_req_i,
    input logic rfsh_gnt_o,
    input logic core_hold_req_o,
    input logic core_hold_ack_i
);
    logic [2:0] gnts;
    assign gnts = {ext_hold_gnt_o, !cas_ack_n_o, rfsh_gnt_o};

    a_r9_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnts));

    a_r9_dead_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (gnts != 3'b000 && $past(gnts) != gnts) |-> ($past(gnts) == 3'b000));

    a_r3_ack_first: assert property (@(posedge clk) disable iff (!rst_n)
        (gnts != 3'b000 && $past(gnts) == 3'b000) |-> $past(core_hold_ack_i));

    a_r10_req_covers_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (gnts != 3'b000) |-> core_hold_req_o);

    a_r6_hold_withdrawn: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_hold_gnt_o && rfsh_req_i) |=> !ext_hold_gnt_o);

    a_r6_dma_withdrawn: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_ack_n_o && rfsh_req_i) |=> cas_ack_n_o);

    a_r8_refresh_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_gnt_o && rfsh_req_i) |=> rfsh_gnt_o);
endmodule

bind bus_arbiter arb_checker u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .ext_hold_gnt_o  (ext_hold_gnt_o),
    .cas_ack_n_o     (cas_ack_n_o),
    .rfsh_req_i      (rfsh_req_i),
    .rfsh_gnt_o      (rfsh_gnt_o),
    .core_hold_req_o (core_hold_req_o),
    .core_hold_ack_i (core_hold_ack_i)
);

// File: tb/sim_bus_arbiter.sv
`timescale 1ns/1ps
module sim_bus_arbiter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold = 1'b0, dreq = 1'b0, rfsh = 1'b0;
    logic hlda, dack_n, rgnt, hreq;
    logic core_ack;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_ack <= 1'b0;
        else        core_ack <= hreq;
    end

    bus_arbiter #(.SYNC_STAGES(2)) u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .ext_hold_i      (hold),
        .ext_hold_gnt_o  (hlda),
        .cas_req_i       (dreq),
        .cas_ack_n_o     (dack_n),
        .rfsh_req_i      (rfsh),
        .rfsh_gnt_o      (rgnt),
        .core_hold_req_o (hreq),
        .core_hold_ack_i (core_ack)
    );

    // {hold, dreq, rfsh} -> expected {hlda, dack_n, rgnt, hreq}
    localparam logic [6:0] VEC [16] = '{
        7'b000_0100, // R1 idle
        7'b100_1101, // R5 hold granted
        7'b110_1101, // R5 DMA does not preempt hold
        7'b010_0001, // R11 hold drops, DMA served
        7'b011_0111, // R6 refresh withdraws DMA
        7'b010_0100, // R7 DMA locked out
        7'b000_0100, // R7 release
        7'b010_0001, // R7 DMA granted again
        7'b000_0100, // R10 idle
        7'b101_0111, // R4 refresh beats hold
        7'b100_1101, // R4 hold next
        7'b101_0111, // R6 refresh withdraws hold
        7'b100_0100, // R7 hold locked out
        7'b000_0100, // R7 release
        7'b100_1101, // R7 hold granted again
        7'b000_0100  // R10 idle
    };

    function automatic string vtag(int i);
        case (i)
            0: return "R1";
            1, 2: return "R5";
            3: return "R11";
            4, 11: return "R6";
            9, 10: return "R4";
            8, 15: return "R10";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input logic [3:0] act, input logic [3:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b ({hlda,dack_n,rgnt,hreq})", req, act, exp);
        end
    endtask

    task automatic sample_after(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #2 check({hlda, dack_n, rgnt, hreq}, 4'b0100, "R1 in reset");
        @(negedge clk) rst_n = 1'b1;
        sample_after(3);
        check({hlda, dack_n, rgnt, hreq}, 4'b0100, "R1 after reset");

        // Vector table walk
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            {hold, dreq, rfsh} = VEC[i][6:4];
            sample_after(10);
            check({hlda, dack_n, rgnt, hreq}, VEC[i][3:0], vtag(i));
        end

        // R2 / R3: exact latency from idle
        @(negedge clk) hold = 1'b1;
        sample_after(2);
        check({hlda, dack_n, rgnt, hreq}, 4'b0100, "R2 no request at edge 2");
        sample_after(1);
        check({hlda, dack_n, rgnt, hreq}, 4'b0101, "R2 request at edge 3");
        sample_after(1);
        check({hlda, dack_n, rgnt, hreq}, 4'b0101, "R3 grant waits for ack");
        sample_after(1);
        check({hlda, dack_n, rgnt, hreq}, 4'b1101, "R3 grant after ack");

        // R6 / R9: withdrawal then dead cycle then refresh
        @(negedge clk) rfsh = 1'b1;
        sample_after(1);
        check({hlda, dack_n, rgnt, hreq}, 4'b0101, "R9 dead cycle on withdrawal");
        sample_after(1);
        check({hlda, dack_n, rgnt, hreq}, 4'b0111, "R6 refresh granted");
        sample_after(6);
        check({hlda, dack_n, rgnt, hreq}, 4'b0111, "R8 refresh grant held");
        @(negedge clk) rfsh = 1'b0;
        sample_after(1);
        check({hlda, dack_n, rgnt, hreq}, 4'b0101, "R8 refresh grant drops");
        sample_after(6);
        check({hlda, dack_n, rgnt, hreq}, 4'b0100, "R7 hold ignored while locked");

        // R7: one-clock release pulse clears lockout
        @(negedge clk) hold = 1'b0;
        @(negedge clk) hold = 1'b1;
        sample_after(10);
        check({hlda, dack_n, rgnt, hreq}, 4'b1101, "R7 granted after one-clock release");

        // R11: owner drops while DMA pending, one dead cycle then DMA
        @(negedge clk) dreq = 1'b1;
        sample_after(6);
        check({hlda, dack_n, rgnt, hreq}, 4'b1101, "R5 hold kept with DMA pending");
        @(negedge clk) hold = 1'b0;
        sample_after(3);
        check({hlda, dack_n, rgnt, hreq}, 4'b0101, "R11 dead cycle after release");
        sample_after(1);
        check({hlda, dack_n, rgnt, hreq}, 4'b0001, "R11 DMA served");

        // R1: reset during a grant
        @(negedge clk) rst_n = 1'b0;
        #2 check({hlda, dack_n, rgnt, hreq}, 4'b0100, "R1 reset mid-grant");
        @(negedge clk) begin
            dreq = 1'b0;
            rst_n = 1'b1;
        end
        sample_after(4);
        check({hlda, dack_n, rgnt, hreq}, 4'b0100, "R10 idle after reset");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule